// File: doc/BRIEF.md
# Interrupt Routing Register File with Indexed Window Access

This block holds the configuration of an I/O interrupt router. The CPU reaches it through two ports only. One is an index register and the other is a 32-bit data window. Every internal register is read and written through the window, at whatever index the index register holds. Behind the window there are four kinds of register:

- an identification register;
- a fixed, read-only version word;
- an arbitration ID register, which takes the identification value whenever that value is written;
- a table of 24 routing entries, each 64 bits wide.

Each entry sets the following for one interrupt input line:

- the vector;
- the delivery style;
- whether the destination is picked statically (physical) or dynamically (logical);
- edge or level trigger;
- a mask;
- an 8-bit destination.

The block also drives the decoded entry fields and the arbitration ID out to the neighbouring blocks. It takes in a per-line remote-IRR status bit, which software can read back but cannot write.

The CPU port has one select bit: 0 picks the index register and 1 picks the window. There is a write strobe and a read strobe. Reads are served by a two-state machine:

- S_IDLE is the state with no response pending.
- S_RESP presents one response word, with `bus_rvalid` high.
- The accept transition (S_IDLE to S_RESP) is taken when a read strobe arrives without a write strobe.
- The retire transition (S_RESP to S_IDLE) is taken when no new read arrives.
- The back-to-back transition (S_RESP to S_RESP) is taken when another read follows at once.

Top module: `ioroute_regfile`

## Requirements
- R1: After reset the index register, the identification register and the arbitration ID are zero, `bus_rvalid` is low, and every entry has its mask bit set with all other stored bits clear.
- R2: A write with `bus_sel`=0 loads `bus_wdata[7:0]` into the index register. A read with `bus_sel`=0 returns the index in bits [7:0], with bits [31:8] reading zero.
- R3: Index 0x00 is the identification register. The ID is held in window bits [27:24], all other bits read zero, and a window write at index 0x00 updates it.
- R4: A window write at index 0x00 also loads the same 4-bit value into the arbitration ID. The arbitration ID appears on `arb_id` from the next cycle and reads at index 0x02 in bits [27:24]. A window write at index 0x02 has no effect.
- R5: Index 0x01 reads 0x00170011: bits [23:16] hold the highest entry number (23) and bits [7:0] hold the version code 0x11. Writes to index 0x01 have no effect.
- R6: Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. The low-word fields are vector [7:0], delivery mode [10:8], destination mode [11], remote-IRR [14], trigger mode [15] and mask [16]. The high word holds the destination in [31:24]. All other bits read zero.
- R7: Low-word bit 14 of entry n reads the `remote_irr[n]` input, and writes to that bit are discarded.
- R8: The decoded outputs follow the stored entry fields from the cycle after the write. Entry n's fields sit at slices `[n*8 +: 8]` of `ent_vector` and `ent_dest`, at `[n*3 +: 3]` of `ent_dlv`, and at bit n of `ent_dmode`, `ent_trig` and `ent_mask`.
- R9: A read at an unimplemented index (0x03 to 0x0F, or 0x40 and above) returns zero. A write there changes no register.
- R10: A read strobe without a write strobe produces `bus_rvalid` high for exactly one cycle, one cycle later, with the data sampled at the strobe. If read and write strobes come together, the write is performed and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | 0 = index register, 1 = data window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read response data |
| bus_rvalid | output | 1 | Read response valid |
| remote_irr | input | 24 | Remote-IRR status per line |
| arb_id | output | 4 | Arbitration ID |
| ent_vector | output | 192 | Vector per entry, 8 bits each |
| ent_dlv | output | 72 | Delivery mode per entry, 3 bits each |
| ent_dmode | output | 24 | Destination mode per entry |
| ent_trig | output | 24 | Trigger mode per entry |
| ent_mask | output | 24 | Mask per entry |
| ent_dest | output | 192 | Destination per entry, 8 bits each |

## Verification
Window accesses are driven at every register class, and each class tells a different thing apart:

- Reads of the first and last table entries after reset separate the low-word and high-word address decode at both ends of the table.
- An all-ones write into an entry separates writable from reserved and read-only bits.
- A distinct field pattern written into entry 5 shows that each field lands both in the window readback and in the correct output slice.
- Writes at index 0x02, at index 0x01, at 0x03 and past the table distinguish ignored targets from live ones.
- A write issued together with a read shows that collisions give priority to the write.

// File: rtl/ioroute_pkg.sv
package ioroute_pkg;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
    } rte_t;

    localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                   dmode: 1'b0, dlv: 3'd0, vec: 8'h00};

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam int unsigned IDX_TBL = 16;

    typedef enum logic {S_IDLE, S_RESP} rd_state_t;

    function automatic logic [31:0] lo_word(rte_t e, logic irr);
        return {15'b0, e.mask, e.trig, irr, 2'b0, e.dmode, e.dlv, e.vec};
    endfunction

    function automatic logic [31:0] hi_word(rte_t e);
        return {e.dest, 24'b0};
    endfunction

endpackage

// File: rtl/ioroute_entry.sv
module ioroute_entry
    import ioroute_pkg::*;
#(
    parameter int unsigned IDX_LO = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_we,
    input  logic [7:0] idx,
    input  rte_t       wr_val,
    output rte_t       q
);
    localparam logic [7:0] IDX_HI_C = 8'(IDX_LO + 1);
    localparam logic [7:0] IDX_LO_C = 8'(IDX_LO);

    logic we_lo, we_hi;
    assign we_lo = win_we && (idx == IDX_LO_C);
    assign we_hi = win_we && (idx == IDX_HI_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RTE_RESET;
        end else if (we_lo) begin
            q.vec   <= wr_val.vec;
            q.dlv   <= wr_val.dlv;
            q.dmode <= wr_val.dmode;
            q.trig  <= wr_val.trig;
            q.mask  <= wr_val.mask;
        end else if (we_hi) begin
            q.dest  <= wr_val.dest;
        end
    end

    // R9: an entry only moves when one of its own two indices is written
    p_entry_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && (idx == IDX_LO_C || idx == IDX_HI_C)) |=> $stable(q));

endmodule

// File: rtl/ioroute_rdmux.sv
module ioroute_rdmux
    import ioroute_pkg::*;
#(
    parameter int unsigned N_ENT    = 24,
    parameter int unsigned ID_W     = 4,
    parameter logic [7:0]  VER_CODE = 8'h11
) (
    input  logic [7:0]       idx,
    input  rte_t             tbl [N_ENT],
    input  logic [N_ENT-1:0] irr,
    input  logic [ID_W-1:0]  id_val,
    input  logic [ID_W-1:0]  arb_val,
    output logic [31:0]      rd_word
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(N_ENT - 1), 8'h00, VER_CODE};

    always_comb begin
        rd_word = '0;
        if (idx == IDX_ID) begin
            rd_word[24 +: ID_W] = id_val;
        end else if (idx == IDX_VER) begin
            rd_word = VER_WORD;
        end else if (idx == IDX_ARB) begin
            rd_word[24 +: ID_W] = arb_val;
        end else begin
            for (int k = 0; k < int'(N_ENT); k++) begin
                if (idx == 8'(IDX_TBL + 2 * k))
                    rd_word = lo_word(tbl[k], irr[k]);
                else if (idx == 8'(IDX_TBL + 2 * k + 1))
                    rd_word = hi_word(tbl[k]);
            end
        end
    end

endmodule

// File: rtl/ioroute_regfile.sv
module ioroute_regfile
    import ioroute_pkg::*;
#(
    parameter int unsigned N_ENT    = 24,
    parameter int unsigned ID_W     = 4,
    parameter logic [7:0]  VER_CODE = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [N_ENT-1:0]   remote_irr,
    output logic [ID_W-1:0]    arb_id,
    output logic [N_ENT*8-1:0] ent_vector,
    output logic [N_ENT*3-1:0] ent_dlv,
    output logic [N_ENT-1:0]   ent_dmode,
    output logic [N_ENT-1:0]   ent_trig,
    output logic [N_ENT-1:0]   ent_mask,
    output logic [N_ENT*8-1:0] ent_dest
);
    rd_state_t   state, state_nxt;
    logic [7:0]  idx_q;
    logic [ID_W-1:0] id_q, arb_q;
    logic        win_we, idx_we, id_we, rd_go;
    logic [31:0] win_word;
    rte_t        wr_val;
    rte_t        tbl [N_ENT];
    logic        wdata_unused;

    assign idx_we = bus_wr && !bus_sel;
    assign win_we = bus_wr && bus_sel;
    assign id_we  = win_we && (idx_q == IDX_ID);
    assign rd_go  = bus_rd && !bus_wr;

    assign wr_val = '{dest: bus_wdata[31:24], mask: bus_wdata[16],
                      trig: bus_wdata[15], dmode: bus_wdata[11],
                      dlv: bus_wdata[10:8], vec: bus_wdata[7:0]};
    assign wdata_unused = ^{bus_wdata[23:17], bus_wdata[14:12]};

    // index, identification and arbitration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
        end else begin
            if (idx_we) idx_q <= bus_wdata[7:0];
            if (id_we) begin
                id_q  <= bus_wdata[24 +: ID_W];
                arb_q <= bus_wdata[24 +: ID_W];
            end
        end
    end

    // routing table
    for (genvar g = 0; g < int'(N_ENT); g++) begin : g_ent
        ioroute_entry #(.IDX_LO(IDX_TBL + 2 * g)) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .win_we (win_we),
            .idx    (idx_q),
            .wr_val (wr_val),
            .q      (tbl[g])
        );
        assign ent_vector[g*8 +: 8] = tbl[g].vec;
        assign ent_dlv[g*3 +: 3]    = tbl[g].dlv;
        assign ent_dmode[g]         = tbl[g].dmode;
        assign ent_trig[g]          = tbl[g].trig;
        assign ent_mask[g]          = tbl[g].mask;
        assign ent_dest[g*8 +: 8]   = tbl[g].dest;
    end

    ioroute_rdmux #(.N_ENT(N_ENT), .ID_W(ID_W), .VER_CODE(VER_CODE)) u_rdmux (
        .idx     (idx_q),
        .tbl     (tbl),
        .irr     (remote_irr),
        .id_val  (id_q),
        .arb_val (arb_q),
        .rd_word (win_word)
    );

    // read response state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: state_nxt = rd_go ? S_RESP : S_IDLE;   // accept
            S_RESP: state_nxt = rd_go ? S_RESP : S_IDLE;   // back-to-back / retire
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= bus_sel ? win_word : {24'b0, idx_q};
    end

    assign bus_rvalid = (state == S_RESP);
    assign arb_id     = arb_q;

    p_resp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> bus_rvalid);
    p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !bus_rvalid);
    p_arb_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        id_we |=> (arb_id == $past(bus_wdata[24 +: ID_W])));
    p_arb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !id_we |=> $stable(arb_id));

endmodule

// File: tb/ioroute_regfile_bench.sv
module ioroute_regfile_bench;
    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [N-1:0]    remote_irr = '0;
    logic [3:0]      arb_id;
    logic [N*8-1:0]  ent_vector, ent_dest;
    logic [N*3-1:0]  ent_dlv;
    logic [N-1:0]    ent_dmode, ent_trig, ent_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    ioroute_regfile u_ioroute_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .remote_irr(remote_irr), .arb_id(arb_id),
        .ent_vector(ent_vector), .ent_dlv(ent_dlv), .ent_dmode(ent_dmode),
        .ent_trig(ent_trig), .ent_mask(ent_mask), .ent_dest(ent_dest)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected response actual=%08h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(logic sel, logic [31:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic sel, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic win_write(logic [7:0] i, logic [31:0] d);
        bus_write(1'b0, {24'b0, i});
        bus_write(1'b1, d);
    endtask

    task automatic win_read(logic [7:0] i, logic [31:0] exp, string tag);
        bus_write(1'b0, {24'b0, i});
        bus_read(1'b1, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        chk("R1 arb_id", {28'b0, arb_id}, 32'h0);
        chk("R1 mask all set", {8'b0, ent_mask}, 32'h00FF_FFFF);
        chk("R1 vectors clear", {31'b0, |ent_vector}, 32'h0);
        bus_read(1'b0, 32'h0, "R1 index reset");
        win_read(8'h00, 32'h0, "R1 id reset");
        win_read(8'h10, 32'h0001_0000, "R1 R6 entry0 low reset");
        win_read(8'h11, 32'h0, "R1 R6 entry0 high reset");
        win_read(8'h3E, 32'h0001_0000, "R1 R6 entry23 low reset");
        win_read(8'h3F, 32'h0, "R1 R6 entry23 high reset");

        // R2 index register
        bus_write(1'b0, 32'h0000_002A);
        bus_read(1'b0, 32'h0000_002A, "R2 index readback");
        bus_write(1'b0, 32'hFFFF_FF55);
        bus_read(1'b0, 32'h0000_0055, "R2 index upper bits zero");

        // R3 / R4 identification and arbitration
        win_write(8'h00, 32'hF5A5_5A5A);
        win_read(8'h00, 32'h0500_0000, "R3 id readback");
        chk("R4 arb_id follows id", {28'b0, arb_id}, 32'h5);
        win_read(8'h02, 32'h0500_0000, "R4 arb via window");
        win_write(8'h02, 32'h0F00_0000);
        win_read(8'h02, 32'h0500_0000, "R4 arb write ignored");
        chk("R4 arb_id unchanged", {28'b0, arb_id}, 32'h5);

        // R5 version
        win_read(8'h01, 32'h0017_0011, "R5 version");
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, 32'h0017_0011, "R5 version write ignored");

        // R6 / R7 all-ones into entry 3, irr low then high
        win_write(8'h16, 32'hFFFF_FFFF);
        win_read(8'h16, 32'h0001_8FFF, "R6 R7 entry3 low reserved zero");
        win_write(8'h17, 32'hFFFF_FFFF);
        win_read(8'h17, 32'hFF00_0000, "R6 entry3 high reserved zero");
        remote_irr[3] = 1'b1;
        win_read(8'h16, 32'h0001_CFFF, "R7 remote irr visible");
        remote_irr[3] = 1'b0;

        // R8 field outputs for entry 5
        win_write(8'h1A, 32'h0000_8D42);
        win_write(8'h1B, 32'hA700_0000);
        win_read(8'h1A, 32'h0000_8D42, "R6 entry5 low");
        chk("R8 vector", {24'b0, ent_vector[5*8 +: 8]}, 32'h42);
        chk("R8 dlv", {29'b0, ent_dlv[5*3 +: 3]}, 32'h5);
        chk("R8 dmode trig mask", {29'b0, ent_dmode[5], ent_trig[5], ent_mask[5]}, 32'h6);
        chk("R8 dest", {24'b0, ent_dest[5*8 +: 8]}, 32'hA7);
        chk("R8 neighbour untouched", {31'b0, ent_mask[4]}, 32'h1);

        // R9 unimplemented indices
        win_write(8'h03, 32'hFFFF_FFFF);
        win_read(8'h03, 32'h0, "R9 index 0x03 reads zero");
        win_write(8'h40, 32'hFFFF_FFFF);
        win_read(8'h40, 32'h0, "R9 index 0x40 reads zero");
        win_read(8'h3E, 32'h0001_0000, "R9 entry23 unchanged");
        win_read(8'h00, 32'h0500_0000, "R9 id unchanged");

        // R10 write wins over simultaneous read
        bus_write(1'b0, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'h0A00_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        chk("R10 no response on collision", {31'b0, bus_rvalid}, 32'h0);
        chk("R10 R4 collision write done", {28'b0, arb_id}, 32'hA);

        // R10 back-to-back reads
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1;
        exp_q.push_back(32'h0A00_0000); tag_q.push_back("R10 back-to-back 1");
        @(negedge clk);
        bus_sel = 1'b0;
        exp_q.push_back(32'h0000_0000); tag_q.push_back("R10 back-to-back 2");
        @(negedge clk);
        bus_rd = 1'b0;

        repeat (4) @(negedge clk);
        chk("R10 all responses seen", exp_q.size(), 32'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule